// File: doc/BRIEF.md
# Disk Read Word Synchronizer

This block sits behind a data separator on the disk read path. It takes the recovered serial bit level and makes its own bit-cell clock enable from the system clock. The bit-cell length is selectable between a fast cell and a slow cell. The block shifts each sampled bit into a 16-bit window and decides where each word begins. It then reports each finished word with a one-clock strobe.

There are three framing modes. In free-running mode, words are cut every 16 bits from the moment reading starts. In pattern mode, nothing is delivered until the window equals a separately held 16-bit sync pattern. Every 16 bits after that match form one word, and each match raises a one-clock pulse. In leading-one mode, used for GCR-style data, zero bits between words are skipped. Each word begins at a 1 bit, and that bit becomes the word's most significant bit.

Top module: `dsync_top`

## Requirements
- R1: After reset, `wordValid` and `syncFound` are 0 and `wordOut` is 0x0000.
- R2: While `readEn` is high, one bit of `rdBit` is sampled every CELL_FAST clocks when `fastCell` is 1, and every CELL_SLOW clocks when it is 0. The cell counter restarts when reading starts, so the first sample falls on the CELL_FAST-th (or CELL_SLOW-th) rising edge with `readEn` high.
- R3: With both framing modes off, a word is delivered after every 16 sampled bits, counted from the start of the read. The first sampled bit of a word lands in bit 15 of `wordOut`.
- R4: With `patSyncEn` set, no word is delivered until the last 16 sampled bits equal `syncPattern` (earliest bit in bit 15). A window is compared only once 16 bits have been sampled in the current read.
- R5: After a pattern match, the next 16 sampled bits form the first word. A word follows every 16 bits after that.
- R6: `syncFound` is a one-clock pulse on every pattern match, including matches inside data. A match inside data does not move the word boundary, so `syncFound` and `wordValid` can be high in the same cycle.
- R7: With `leadOneEn` set and `patSyncEn` clear, 0 bits seen while waiting for a word are discarded. A word starts at a sampled 1, which becomes bit 15, and waiting starts again after each word.
- R8: When both `patSyncEn` and `leadOneEn` are set, pattern framing applies and the leading-one rule is ignored.
- R9: While `readEn` is low, the strobes stay low and any partial word is dropped. Each new read starts framing afresh.
- R10: `wordValid` lasts one clock per word. `wordOut` keeps the last delivered word until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| readEn | input | 1 | High while a read is in progress; low clears framing |
| fastCell | input | 1 | 1 selects the fast bit cell, 0 the slow one |
| patSyncEn | input | 1 | Enables framing on the sync pattern |
| leadOneEn | input | 1 | Enables framing on a leading 1 bit |
| syncPattern | input | 16 | Sync pattern to hunt for |
| rdBit | input | 1 | Recovered serial read data |
| wordValid | output | 1 | One-clock strobe per delivered word |
| wordOut | output | 16 | Last delivered word |
| syncFound | output | 1 | One-clock pulse per pattern match |

## Verification
Word delivery and pattern detection can land on the same bit. This happens when a data word that follows a match is itself equal to the sync pattern. The bench provokes it by sending the pattern twice in a row and then more data. It expects `syncFound` alone on the first match, then `syncFound` and `wordValid` together with `wordOut` equal to the pattern, with word spacing unchanged afterwards. A behavioural model that works on queues of bits predicts all three outputs on every clock.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  typedef enum logic {HUNT = 1'b0, COLLECT = 1'b1} frameState_t;

  typedef struct packed {
    logic emitWord;
    logic syncHit;
  } dsyncCtl_t;
endpackage

// File: rtl/dsync_datapath.sv
module dsync_datapath
  import dsync_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CELL_FAST = 200,
  parameter int CELL_SLOW = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readEn,
  input  logic              fastCell,
  input  logic              rdBit,
  input  logic [WORD_W-1:0] syncPattern,
  input  dsyncCtl_t         ctl,
  output logic              bitTick,
  output logic              windowHit,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordOut,
  output logic              syncFound
);
  localparam int CELL_W = $clog2(CELL_SLOW + 1);
  localparam logic [CELL_W-1:0] FAST_LAST = CELL_W'(CELL_FAST - 1);
  localparam logic [CELL_W-1:0] SLOW_LAST = CELL_W'(CELL_SLOW - 1);

  logic [CELL_W-1:0] cellCnt;
  logic [CELL_W-1:0] cellLast;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextShift;

  assign cellLast  = fastCell ? FAST_LAST : SLOW_LAST;
  assign bitTick   = readEn && (cellCnt >= cellLast);
  assign nextShift = {shiftReg[WORD_W-2:0], rdBit};
  assign windowHit = (nextShift == syncPattern);

  always_ff @(posedge clk) begin
    if (!rstN || !readEn) begin
      cellCnt <= '0;
    end else if (bitTick) begin
      cellCnt <= '0;
    end else begin
      cellCnt <= cellCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !readEn) begin
      shiftReg <= '0;
    end else if (bitTick) begin
      shiftReg <= nextShift;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      syncFound <= 1'b0;
      wordOut   <= '0;
    end else begin
      wordValid <= ctl.emitWord;
      syncFound <= ctl.syncHit;
      if (ctl.emitWord) wordOut <= nextShift;
    end
  end

  assert_cell_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cellCnt < CELL_W'(CELL_SLOW));

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);
endmodule

// File: rtl/dsync_control.sv
module dsync_control
  import dsync_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      readEn,
  input  logic      patSyncEn,
  input  logic      leadOneEn,
  input  logic      bitTick,
  input  logic      rdBit,
  input  logic      windowHit,
  output dsyncCtl_t ctl
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  frameState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic [CNT_W-1:0] fillCnt;
  logic windowFull;
  logic patHit;

  assign windowFull = (fillCnt == LAST_BIT);
  assign patHit     = windowHit && windowFull;

  always_comb begin
    stateNext    = state;
    bitCntNext   = bitCnt;
    ctl.emitWord = 1'b0;
    ctl.syncHit  = 1'b0;
    if (bitTick) begin
      if (patSyncEn) begin
        if (state == HUNT) begin
          if (patHit) begin
            ctl.syncHit = 1'b1;
            stateNext   = COLLECT;
            bitCntNext  = '0;
          end
        end else begin
          ctl.syncHit  = patHit;
          ctl.emitWord = (bitCnt == LAST_BIT);
          bitCntNext   = (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
        end
      end else if (leadOneEn) begin
        if (state == HUNT) begin
          if (rdBit) begin
            stateNext  = COLLECT;
            bitCntNext = CNT_W'(1);
          end
        end else if (bitCnt == LAST_BIT) begin
          ctl.emitWord = 1'b1;
          stateNext    = HUNT;
          bitCntNext   = '0;
        end else begin
          bitCntNext = bitCnt + 1'b1;
        end
      end else begin
        ctl.emitWord = (bitCnt == LAST_BIT);
        bitCntNext   = (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !readEn) begin
      state   <= HUNT;
      bitCnt  <= '0;
      fillCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
      if (bitTick && !windowFull) fillCnt <= fillCnt + 1'b1;
    end
  end

  assert_hunt_no_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == HUNT && patSyncEn) |-> !ctl.emitWord);

  assert_strobe_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emitWord || ctl.syncHit) |-> bitTick);
endmodule

// File: rtl/dsync_top.sv
module dsync_top
  import dsync_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CELL_FAST = 200,
  parameter int CELL_SLOW = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readEn,
  input  logic              fastCell,
  input  logic              patSyncEn,
  input  logic              leadOneEn,
  input  logic [WORD_W-1:0] syncPattern,
  input  logic              rdBit,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordOut,
  output logic              syncFound
);
  dsyncCtl_t ctl;
  logic bitTick;
  logic windowHit;

  dsync_datapath #(.WORD_W(WORD_W), .CELL_FAST(CELL_FAST), .CELL_SLOW(CELL_SLOW)) uData (
    .clk(clk), .rstN(rstN), .readEn(readEn), .fastCell(fastCell), .rdBit(rdBit),
    .syncPattern(syncPattern), .ctl(ctl), .bitTick(bitTick), .windowHit(windowHit),
    .wordValid(wordValid), .wordOut(wordOut), .syncFound(syncFound)
  );

  dsync_control #(.WORD_W(WORD_W)) uCtl (
    .clk(clk), .rstN(rstN), .readEn(readEn), .patSyncEn(patSyncEn),
    .leadOneEn(leadOneEn), .bitTick(bitTick), .rdBit(rdBit),
    .windowHit(windowHit), .ctl(ctl)
  );

  assert_word_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  assert_sync_needs_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    syncFound |-> $past(patSyncEn));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !readEn |=> (!wordValid && !syncFound));

  assert_lead_one_msb_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && $past(leadOneEn && !patSyncEn)) |-> wordOut[WORD_W-1]);
endmodule

// File: tb/tb_dsync_top.sv
module tb_dsync_top;
  localparam int FAST = 5;
  localparam int SLOW = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readEn = 1'b0;
  logic fastCell = 1'b1;
  logic patSyncEn = 1'b0;
  logic leadOneEn = 1'b0;
  logic [15:0] syncPattern = 16'h4489;
  logic rdBit = 1'b0;
  logic wordValid;
  logic [15:0] wordOut;
  logic syncFound;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";
  bit done = 1'b0;

  dsync_top #(.WORD_W(16), .CELL_FAST(FAST), .CELL_SLOW(SLOW)) dut (
    .clk(clk), .rstN(rstN), .readEn(readEn), .fastCell(fastCell),
    .patSyncEn(patSyncEn), .leadOneEn(leadOneEn), .syncPattern(syncPattern),
    .rdBit(rdBit), .wordValid(wordValid), .wordOut(wordOut), .syncFound(syncFound)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  bit expWv = 0, expSf = 0;
  bit [15:0] expWd = 0;
  int mCnt = 0, fill = 0;
  bit locked = 0;
  bit [15:0] win = 0;
  bit acc[$];

  always @(posedge clk) begin
    if (!rstN) begin
      expWv = 0; expSf = 0; expWd = 0;
      mCnt = 0; fill = 0; locked = 0; win = 0; acc.delete();
    end else begin
      expWv = 0; expSf = 0;
      if (!readEn) begin
        mCnt = 0; fill = 0; locked = 0; win = 0; acc.delete();
      end else begin
        mCnt++;
        if (mCnt >= (fastCell ? FAST : SLOW)) begin
          bit b;
          bit hit;
          mCnt = 0;
          b = rdBit;
          win = {win[14:0], b};
          if (fill < 16) fill++;
          hit = (fill == 16) && (win == syncPattern);
          if (patSyncEn) begin
            if (!locked) begin
              if (hit) begin expSf = 1; locked = 1; end
            end else begin
              expSf = hit;
              acc.push_back(b);
            end
          end else if (leadOneEn) begin
            if (acc.size() != 0 || b) acc.push_back(b);
          end else begin
            acc.push_back(b);
          end
          if (acc.size() == 16) begin
            expWv = 1;
            for (int i = 0; i < 16; i++) expWd[15-i] = acc[i];
            acc.delete();
          end
        end
      end
    end
  end

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (wordValid !== expWv) fail(curReq, "wordValid", wordValid, expWv);
      if (syncFound !== expSf) fail("R6", "syncFound", syncFound, expSf);
      if (wordOut !== expWd) fail(expWv ? curReq : "R10", "wordOut", wordOut, expWd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  bit q[$];

  task automatic pushWord(input bit [15:0] w);
    for (int i = 15; i >= 0; i--) q.push_back(w[i]);
  endtask

  task automatic pushRand(input int n);
    for (int i = 0; i < n; i++) q.push_back(1'($urandom_range(0, 1)));
  endtask

  task automatic runRead(input bit fast);
    fastCell = fast;
    readEn = 1'b1;
    for (int i = 0; i < q.size(); i++) begin
      rdBit = q[i];
      repeat (fast ? FAST : SLOW) @(negedge clk);
    end
    readEn = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (wordValid !== 1'b0 || syncFound !== 1'b0 || wordOut !== 16'h0)
      fail("R1", "reset outputs", {wordValid, syncFound, wordOut}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: free running, fast cell
    curReq = "R3";
    pushRand(40);
    runRead(1'b1);

    // R2: slow cell, first word timing
    curReq = "R2";
    begin
      int k = 0;
      fastCell = 1'b0;
      rdBit = 1'b1;
      readEn = 1'b1;
      while (!wordValid && k < 1000) begin
        @(negedge clk);
        k++;
      end
      checks++;
      if (k != 16 * SLOW) fail("R2", "cycles to first word", k, 16 * SLOW);
      readEn = 1'b0;
      repeat (3) @(negedge clk);
    end
    pushRand(33);
    runRead(1'b0);

    // R4/R5: pattern framing
    curReq = "R5";
    patSyncEn = 1'b1;
    pushWord(16'h0000);
    pushRand(7);
    pushWord(16'h4489);
    pushWord(16'hA5C3);
    pushWord(16'h0F0F);
    pushWord(16'h8001);
    runRead(1'b1);

    curReq = "R4";
    pushRand(12);
    pushWord(16'h1234);
    runRead(1'b1);

    // R6: match coinciding with a word boundary
    curReq = "R6";
    pushRand(5);
    pushWord(16'h4489);
    pushWord(16'h4489);
    pushWord(16'h7E11);
    runRead(1'b0);

    // R8: both modes, pattern wins, word with leading zeros kept
    curReq = "R8";
    leadOneEn = 1'b1;
    pushWord(16'h4489);
    pushWord(16'h0123);
    pushWord(16'h0001);
    runRead(1'b1);

    // R7: leading-one framing
    curReq = "R7";
    patSyncEn = 1'b0;
    q.push_back(0); q.push_back(0); q.push_back(0);
    pushWord(16'hB00F);
    q.push_back(0); q.push_back(0);
    pushWord(16'h8000);
    pushRand(20);
    runRead(1'b1);

    // R9: read dropped mid-word, then restarted
    curReq = "R9";
    leadOneEn = 1'b0;
    pushRand(20);
    runRead(1'b1);
    pushRand(40);
    runRead(1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule